// File: doc/BRIEF.md
# Serial Register Port with Polarity Detection and Region-Wrapping Burst Addressing

This block is a serial slave front end that lets an external master read and write a 128-location byte array through four pins: an active-high enable, a serial clock, a data input and a data output with its own output enable. It runs on a faster system clock. All three serial inputs pass through two-stage synchronizers, and the block finds serial clock edges by comparing successive synchronized samples.

Each transaction begins when the enable rises. At that moment the block takes the serial clock's level as its idle level. The first eight bits form a command byte, and every later group of eight bits is a data byte. The block then drives a simple parallel port toward the storage array. This port carries an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that is valid in the same cycle as the read strobe.

Data bytes may follow one another without limit. After each byte the address advances. The lower 32 locations wrap within themselves, and the upper 96 locations wrap back to their own first entry.

Top module: `spi_regport`

## Requirements
- R1: A rising enable starts a transaction and a falling enable ends it. Bits of an unfinished byte are dropped, and the next transaction again begins with a command byte.
- R2: The serial clock level seen when the enable rises is the idle level. With idle level 0, input bits are taken on rising edges and output bits change on falling edges. With idle level 1, input bits are taken on falling edges and output bits change on rising edges.
- R3: Every byte is eight serial clock cycles long and is sent most significant bit first, in both directions.
- R4: In the command byte, bit 7 = 1 selects write, bit 7 = 0 selects read, and bits 6..0 give the start address (00h..7Fh). All data bytes in the transaction go in that one direction.
- R5: After each data byte the address moves to the next location, and this repeats until the enable falls.
- R6: Inside the range 00h..1Fh, the location after 1Fh is 00h.
- R7: Inside the range 20h..7Fh, the location after 7Fh is 20h.
- R8: The output enable is low while the enable input is low and for the whole command byte. It goes high only when a read byte starts to shift out.
- R9: Each completed write data byte produces exactly one single-cycle write strobe, carrying its address and data. A byte that is cut short by the enable falling produces no strobe.
- R10: A read transaction of N bytes makes N+1 single-cycle read strobes. One comes when the command byte completes, and one comes as each data byte completes. The read data is taken in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial enable, active high (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data input (asynchronous) |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |
| mem_addr_o | output | 7 | Storage address |
| mem_wdata_o | output | 8 | Storage write data |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_re_o | output | 1 | Single-cycle read strobe |
| mem_rdata_i | input | 8 | Storage read data, valid in the read strobe cycle |

## Verification
A serial clock edge becomes visible to the logic three system-clock edges after the pin changes. That delay comes from two synchronizer stages plus the register that holds the result.

A write strobe follows its eighth taking edge by about three cycles. The bench loads the expected address and data into a queue before that byte is sent, and it compares every strobe against the head of the queue on every clock. The output enable is checked on every clock once the enable input has been low for four cycles.

Read bits change about three cycles after a shifting edge. The bench samples them just before the next taking edge, six cycles later, so each sample lands well after the change and well before the following one.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  output logic start,
  output logic active,
  output logic lat_stb,
  output logic sft_stb
);

  logic ce_q, sclk_q, pol_q, pol_d;
  logic rise, fall;

  assign start  = ce & ~ce_q;
  assign active = ce & ce_q;
  assign rise   = sclk & ~sclk_q;
  assign fall   = ~sclk & sclk_q;
  assign lat_stb = active & (pol_q ? fall : rise);
  assign sft_stb = active & (pol_q ? rise : fall);

  always_comb begin
    pol_d = pol_q;
    if (start) pol_d = sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      sclk_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      ce_q   <= ce;
      sclk_q <= sclk;
      pol_q  <= pol_d;
    end
  end

  // R2: idle level is frozen for the rest of the transaction
  a_r2_pol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(pol_q));
  // R2: one serial edge is never both taking and shifting
  a_r2_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_stb && sft_stb));

endmodule

// File: rtl/spi_regport_addr.sv
module spi_regport_addr #(
  parameter int AW        = 7,
  parameter int LOW_LAST  = 31,
  parameter int HIGH_FIRST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] TOP_A  = {AW{1'b1}};
  localparam logic [AW-1:0] LOW_L  = AW'(LOW_LAST);
  localparam logic [AW-1:0] HIGH_F = AW'(HIGH_FIRST);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = load_val;
    end else if (inc) begin
      if (addr_q == LOW_L)      addr_d = '0;
      else if (addr_q == TOP_A) addr_d = HIGH_F;
      else                      addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  a_r6_low_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && addr_q == LOW_L) |=> (addr_q == '0));
  a_r7_high_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && addr_q == TOP_A) |=> (addr_q == HIGH_F));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(addr_q));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW         = 7,
  parameter int DW         = 8,
  parameter int LOW_LAST   = 31,
  parameter int HIGH_FIRST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i
);
  import spi_regport_pkg::*;

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  logic [2:0] pins_s;
  logic ce_s, sclk_s, sdi_s;
  spi_regport_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({ce_i, sclk_i, sdi_i}), .q(pins_s)
  );
  assign {ce_s, sclk_s, sdi_s} = pins_s;

  logic start, active, lat_stb, sft_stb;
  spi_regport_edge u_edge (
    .clk(clk), .rst_n(rst_sn), .ce(ce_s), .sclk(sclk_s),
    .start(start), .active(active), .lat_stb(lat_stb), .sft_stb(sft_stb)
  );

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d, wdata_q, wdata_d, rx_full;
  logic          sdo_q, sdo_d, oe_q, oe_d, we_q, we_d, re_q, re_d;
  logic          addr_load, addr_inc, byte_done;
  logic [AW-1:0] addr;

  assign rx_full   = {rx_q[DW-2:0], sdi_s};
  assign byte_done = lat_stb && (cnt_q == LAST_BIT);

  always_comb begin
    phase_d = phase_q;  cnt_d = cnt_q;  rx_d = rx_q;  tx_d = tx_q;
    wdata_d = wdata_q;  sdo_d = sdo_q;  oe_d = oe_q;
    we_d = 1'b0;  re_d = 1'b0;  addr_load = 1'b0;  addr_inc = 1'b0;
    if (!ce_s || start) begin
      phase_d = PH_CMD;  cnt_d = '0;  oe_d = 1'b0;  sdo_d = 1'b0;
    end else if (active) begin
      if (lat_stb) begin
        rx_d  = rx_full;
        cnt_d = byte_done ? '0 : cnt_q + CW'(1);
        if (byte_done) begin
          case (phase_q)
            PH_CMD: begin
              addr_load = 1'b1;
              phase_d   = rx_full[DW-1] ? PH_WRITE : PH_READ;
              re_d      = ~rx_full[DW-1];
            end
            PH_WRITE: begin
              we_d    = 1'b1;
              wdata_d = rx_full;
            end
            default: begin
              addr_inc = 1'b1;
              re_d     = 1'b1;
            end
          endcase
        end
      end
      if (sft_stb && phase_q == PH_READ) begin
        sdo_d = tx_q[DW-1];
        tx_d  = {tx_q[DW-2:0], 1'b0};
        oe_d  = 1'b1;
      end
    end
    if (re_q) tx_d = mem_rdata_i;
    if (we_q) addr_inc = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_CMD;  cnt_q <= '0;  rx_q <= '0;  tx_q <= '0;
      wdata_q <= '0;  sdo_q <= 1'b0;  oe_q <= 1'b0;  we_q <= 1'b0;  re_q <= 1'b0;
    end else begin
      phase_q <= phase_d;  cnt_q <= cnt_d;  rx_q <= rx_d;  tx_q <= tx_d;
      wdata_q <= wdata_d;  sdo_q <= sdo_d;  oe_q <= oe_d;  we_q <= we_d;  re_q <= re_d;
    end
  end

  spi_regport_addr #(.AW(AW), .LOW_LAST(LOW_LAST), .HIGH_FIRST(HIGH_FIRST)) u_addr (
    .clk(clk), .rst_n(rst_sn), .load(addr_load), .load_val(rx_full[AW-1:0]),
    .inc(addr_inc), .addr(addr)
  );

  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = oe_q;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = we_q;
  assign mem_re_o    = re_q;

  a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    !ce_s |=> !sdo_oe_o);
  a_r8_oe_read_only: assert property (@(posedge clk) disable iff (!rst_sn)
    sdo_oe_o |-> (phase_q == PH_READ));
  a_r9_we_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we_o |=> !mem_we_o);
  a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_re_o |=> !mem_re_o);
  a_r4_dir_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_we_o && mem_re_o));
  a_r1_start_cmd: assert property (@(posedge clk) disable iff (!rst_sn)
    start |=> (phase_q == PH_CMD && cnt_q == '0));

endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, mem_we, mem_re;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] store [128];
  logic [7:0] ref_mem [128];
  int exp_wa[$];
  int exp_wd[$];
  int errors = 0, checks = 0, re_count = 0, ce_low = 0;
  bit done = 1'b0;

  always_comb mem_rdata = store[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) store[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_we) begin
      store[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re) re_count++;
      if (mem_we) begin
        if (exp_wa.size() == 0) begin
          chk(1'b0, "R9 unexpected write strobe", int'(mem_addr), -1);
        end else begin
          int a, d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          chk(int'(mem_addr) == a, "R5 write address", int'(mem_addr), a);
          chk(int'(mem_wdata) == d, "R9 write data", int'(mem_wdata), d);
        end
      end
      ce_low = ce ? 0 : ce_low + 1;
      if (ce_low >= 4) chk(!sdo_oe, "R8 oe low while idle", int'(sdo_oe), 0);
    end
  end

  function automatic int next_loc(input int a);
    if (a == 31) return 0;
    if (a == 127) return 32;
    return a + 1;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_x(input bit pol);
    sclk = pol;
    wait_n(4);
    ce = 1'b1;
    wait_n(HALF);
  endtask

  task automatic end_x(input bit pol);
    wait_n(HALF);
    ce = 1'b0;
    sclk = pol;
    wait_n(8);
  endtask

  task automatic send_bits(input bit pol, input logic [7:0] b, input int nbits,
                           output logic [7:0] got, output int oe_ones);
    got = '0;
    oe_ones = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      wait_n(HALF);
      got[i] = sdo;
      if (sdo_oe) oe_ones++;
      sclk = ~pol;
      wait_n(HALF);
      sclk = pol;
    end
  endtask

  task automatic do_write(input bit pol, input int a0, input int n, input int seed);
    logic [7:0] g;
    int o, a;
    a = a0;
    begin_x(pol);
    send_bits(pol, {1'b1, 7'(a0)}, 8, g, o);
    chk(o == 0, "R8 oe low in command byte", o, 0);
    for (int k = 0; k < n; k++) begin
      int d;
      d = (seed + k * 37) & 255;
      exp_wa.push_back(a);
      exp_wd.push_back(d);
      ref_mem[a] = 8'(d);
      send_bits(pol, 8'(d), 8, g, o);
      a = next_loc(a);
    end
    end_x(pol);
    chk(exp_wa.size() == 0, "R9 all write strobes seen", exp_wa.size(), 0);
  endtask

  task automatic do_read(input bit pol, input int a0, input int n, input string tag);
    logic [7:0] g;
    int o, a, r0;
    a = a0;
    r0 = re_count;
    begin_x(pol);
    send_bits(pol, {1'b0, 7'(a0)}, 8, g, o);
    chk(o == 0, "R8 oe low in command byte", o, 0);
    for (int k = 0; k < n; k++) begin
      send_bits(pol, 8'hFF, 8, g, o);
      chk(g == ref_mem[a], tag, int'(g), int'(ref_mem[a]));
      chk(o == 8, "R8 oe high while read byte shifts", o, 8);
      a = next_loc(a);
    end
    end_x(pol);
    chk(re_count - r0 == n + 1, "R10 read strobe count", re_count - r0, n + 1);
  endtask

  initial begin
    logic [7:0] g;
    int o;
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    // reset state
    chk(!sdo_oe, "R8 reset oe", int'(sdo_oe), 0);
    chk(!mem_we, "R9 reset we", int'(mem_we), 0);
    chk(!mem_re, "R10 reset re", int'(mem_re), 0);

    // idle-low burst write across the low-range wrap
    do_write(1'b0, 8'h1E, 3, 8'h11);
    // idle-high burst write across the high-range wrap
    do_write(1'b1, 8'h7E, 3, 8'hA3);
    // read back, both idle levels, R3 bit order with R6 and R7 wraps
    do_read(1'b0, 8'h1E, 3, "R6 low-range read after wrap");
    do_read(1'b1, 8'h7E, 3, "R7 high-range read after wrap");
    do_read(1'b1, 8'h1E, 3, "R2 idle-high read of low range");
    // single-byte cases (R4 direction bit, R3 MSB first)
    do_write(1'b1, 8'h25, 1, 8'h96);
    do_read(1'b0, 8'h25, 1, "R3 single byte MSB first");
    do_read(1'b0, 8'h05, 2, "R4 untouched locations");

    // R1: aborted write byte must not be stored
    begin_x(1'b0);
    send_bits(1'b0, {1'b1, 7'h40}, 8, g, o);
    send_bits(1'b0, 8'hC3, 5, g, o);
    end_x(1'b0);
    do_read(1'b0, 8'h40, 1, "R1 aborted byte not stored");
    // R1: aborted command byte, then a clean write
    begin_x(1'b1);
    send_bits(1'b1, {1'b1, 7'h10}, 3, g, o);
    end_x(1'b1);
    do_write(1'b0, 8'h41, 2, 8'h3C);
    do_read(1'b1, 8'h40, 3, "R5 burst after abort");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule